// File: doc/BRIEF.md
# Hybrid Rule 90/150 Cellular Automaton Pattern Source

This block is a one-dimensional register of cells that produces a pseudorandom sequence of parallel words, for example to drive stimulus into logic under self-test. Every cell moves to its next value on the same clock edge. Each cell computes that value from its two neighbours, and optionally from itself. A per-cell parameter mask chooses between the two linear update rules. No feedback polynomial is involved.

The two end cells have only one real neighbour each. An elaboration-time parameter decides what stands in for the missing one: a constant zero (null wiring) or the cell at the far end (cyclic wiring). A synchronous reset loads a nonzero seed. The register advances only in cycles where the step input is high. The full state is presented on a parallel output.

Top module: `hca_prpg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` takes the low WIDTH bits of SEED after that edge.
- R2: With `rst` low and `step` low at a rising edge, `state` keeps its value.
- R3: A cell whose RULE_150 bit is 0 (rule 90) takes the XOR of its lower and upper neighbours on a step.
- R4: A cell whose RULE_150 bit is 1 (rule 150) takes the XOR of its lower neighbour, its own value and its upper neighbour on a step.
- R5: With CYCLIC = 0, the lower neighbour of cell 0 and the upper neighbour of cell WIDTH-1 read as 0. For example, the default 4-cell register goes from seed 4'b0001 to 4'b0010 in one step.
- R6: With CYCLIC = 1, cell 0 and cell WIDTH-1 serve as each other's missing neighbour. For example, an 8-cell register with RULE_150 = 8'h96 goes from 8'h01 to 8'h82 in one step.
- R7: All cells update together and use only the values they held before the edge.
- R8: Bit i of RULE_150 selects the rule of cell i. The default mask alternates starting at cell 0 (90,150,90,150,...), i.e. 4'b1010 for 4 cells.
- R9: Reset takes priority over `step`: with both high, the seed is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; loads the seed |
| step | input | 1 | Advance the automaton one generation |
| state | output | WIDTH | Current cell values, cell i on bit i |

## Verification
The bench targets the following corner cases and the fault each one exposes:
- **End cells.** The seed has a single one at cell 0. If the missing neighbour were wired wrongly, the very first step would set the wrong end bit. Under null wiring, cell WIDTH-1 would turn on. Under cyclic wiring, bit 7 would fail to turn on.
- **Rule mapping.** Cells with mixed rules run side by side against an independent model over many generations. A swapped mask bit, or a cell that reads its own updated neighbour, makes the two sequences diverge within a few steps.
- **Hold and reset.** Step-low stretches are inserted between runs, and reset is raised while step is high. A design that drifts while idle, or that lets step override reset, would show a changed word or miss the seed.

// File: rtl/hca_prpg.sv
module hca_prpg #(
  parameter int          WIDTH    = 4,
  parameter logic [63:0] RULE_150 = 64'hAAAA_AAAA_AAAA_AAAA,
  parameter bit          CYCLIC   = 1'b0,
  parameter logic [63:0] SEED     = 64'h1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] RULES  = RULE_150[WIDTH-1:0];
  localparam logic [WIDTH-1:0] SEED_W = SEED[WIDTH-1:0];

  logic [WIDTH+1:0] ring;
  logic [WIDTH-1:0] nxt;

  assign ring = {CYCLIC ? state[0] : 1'b0, state, CYCLIC ? state[WIDTH-1] : 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign nxt[i] = ring[i] ^ ring[i+2] ^ (RULES[i] & ring[i+1]);
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED_W;
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/hca_prpg_chk.sv
module hca_prpg_chk #(
  parameter int          WIDTH    = 4,
  parameter logic [63:0] RULE_150 = 64'hAAAA_AAAA_AAAA_AAAA,
  parameter bit          CYCLIC   = 1'b0,
  parameter logic [63:0] SEED     = 64'h1
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] RULES = RULE_150[WIDTH-1:0];

  assert_seed_load_R1_R9: assert property (@(posedge clk)
    rst |=> (state == SEED[WIDTH-1:0]));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));

  for (genvar i = 1; i < WIDTH-1; i++) begin : g_mid
    assert_cell_rule_R3_R4_R7: assert property (@(posedge clk) disable iff (rst)
      step |=> state[i] == ($past(state[i-1]) ^ $past(state[i+1]) ^ (RULES[i] & $past(state[i]))));
  end

  assert_low_edge_R5_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> state[0] == ((CYCLIC & $past(state[WIDTH-1])) ^ $past(state[1]) ^ (RULES[0] & $past(state[0]))));

  assert_high_edge_R5_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> state[WIDTH-1] == ((CYCLIC & $past(state[0])) ^ $past(state[WIDTH-2]) ^ (RULES[WIDTH-1] & $past(state[WIDTH-1]))));
endmodule

bind hca_prpg hca_prpg_chk #(.WIDTH(WIDTH), .RULE_150(RULE_150), .CYCLIC(CYCLIC), .SEED(SEED))
  u_hca_prpg_chk (.clk(clk), .rst(rst), .step(step), .state(state));

// File: tb/test_hca_prpg.sv
module test_hca_prpg;
  localparam logic [63:0] RULE_A = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam logic [63:0] RULE_B = 64'h96;
  localparam logic [63:0] SEED_A = 64'h1;
  localparam logic [63:0] SEED_B = 64'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic [3:0] st_a;
  logic [7:0] st_b;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hca_prpg i_hca_prpg (.clk(clk), .rst(rst), .step(step), .state(st_a));
  hca_prpg #(.WIDTH(8), .RULE_150(RULE_B), .CYCLIC(1'b1), .SEED(SEED_B))
    i_hca_prpg_cyc (.clk(clk), .rst(rst), .step(step), .state(st_b));

  typedef struct {
    logic [63:0] ea;
    logic [63:0] eb;
    string       tag;
  } item_t;
  item_t q[$];
  logic [63:0] m_a, m_b;

  function automatic logic [63:0] gen(input logic [63:0] s, input int w,
                                      input logic [63:0] r, input bit cyc);
    logic [63:0] o = '0;
    for (int i = 0; i < w; i++) begin
      logic lo, hi;
      lo = (i == 0)   ? (cyc ? s[w-1] : 1'b0) : s[i-1];
      hi = (i == w-1) ? (cyc ? s[0]   : 1'b0) : s[i+1];
      o[i] = r[i] ? (lo ^ s[i] ^ hi) : (lo ^ hi);
    end
    return o;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit s, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    step = s;
    if (r) begin
      m_a = SEED_A & 64'hF;
      m_b = SEED_B & 64'hFF;
    end else if (s) begin
      m_a = gen(m_a, 4, RULE_A, 1'b0);
      m_b = gen(m_b, 8, RULE_B, 1'b1);
    end
    it.ea = m_a;
    it.eb = m_b;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial forever begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({60'd0, st_a}, it.ea, {it.tag, " null"});
      check({56'd0, st_b}, it.eb, {it.tag, " cyclic"});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_a = '0;
    m_b = '0;
    cyc(1, 0, "R1 reset seed");
    cyc(0, 0, "R2 idle after reset");
    cyc(0, 1, "R5 R6 first step");
    @(posedge clk);
    #6;
    check({60'd0, st_a}, 64'h2, "R5 null edge directed");
    check({56'd0, st_b}, 64'h82, "R6 cyclic wrap directed");
    for (int k = 0; k < 40; k++) cyc(0, 1, "R3 R4 R7 R8 run");
    for (int k = 0; k < 5; k++) cyc(0, 0, "R2 hold");
    for (int k = 0; k < 20; k++) cyc(0, (k % 3) != 0, "R7 gapped steps");
    cyc(1, 1, "R9 reset over step");
    for (int k = 0; k < 30; k++) cyc(0, 1, "R3 R4 R8 rerun");
    cyc(0, 0, "R2 final hold");
    repeat (3) @(posedge clk);
    #6;
    finish_run();
  end
endmodule